// File: doc/BRIEF.md
# Low-Power Mode Wake-Up Controller

This controller moves a processor core between normal execution and two power-saving states. A one-cycle power-save request with a mode select takes the core from running into Idle, where only the CPU clock is gated, or into Sleep, where the CPU clock, the peripheral clocks and the primary oscillator are all stopped. While in a low-power state the controller watches the interrupt lines, their enables and priorities, the reset causes and the watchdog time-out, and decides when the core must wake.

Leaving Idle costs nothing: the CPU clock returns on the next cycle. Leaving Sleep goes through a wake-wait state in which a programmable down-counter models the oscillator start-up time. When the count runs out and the oscillator is still not ready, the controller either holds the core until the oscillator reports ready, or, when clock-fail monitoring is enabled, raises a one-cycle clock-failure trap and switches to the backup internal oscillator. Three sticky status flags record a wake from Sleep, a wake from Idle and a watchdog wake. A power-on reset clears them; software clears them with per-flag strobes.

Top module: `lpwr_wake_ctrl`

## Requirements
- R1: After `rst_n` the mode is RUN (`mode_state`=0), all status flags and `frc_sel` are 0. In RUN, `psave_req` moves the mode on the next edge to IDLE (1) when `psave_sleep`=0 or to SLEEP (2) when `psave_sleep`=1.
- R2: Clock enables per mode: RUN all of `cpu_clk_en`, `periph_clk_en`, `posc_en` high; IDLE `cpu_clk_en` low with the other two high; SLEEP all three low; WAKE_WAIT (3) `posc_en` high, the other two low.
- R3: An interrupt wake condition exists when some line i has `irq_req[i]`=1, `irq_en[i]`=1 and its priority `irq_prio[PW*i +: PW]` strictly greater than `cpu_ipl`.
- R4: In IDLE a wake condition returns the mode to RUN on the next edge, re-enabling the CPU clock with no extra delay.
- R5: In SLEEP a wake condition moves the mode to WAKE_WAIT and loads the counter from `stab_load`; the counter falls by one per cycle, and with `osc_ready`=1 the mode returns to RUN on the edge after the counter reaches zero (stab_load+1 edges after the wake edge).
- R6: In WAKE_WAIT with the counter at zero, `osc_ready`=0 and `fscm_en`=1, the mode goes to RUN, `frc_sel` is set and stays set until `osc_restore` or a power-on reset, and `cf_trap` is high for exactly one cycle.
- R7: In WAKE_WAIT with the counter at zero, `osc_ready`=0 and `fscm_en`=0, the mode stays WAKE_WAIT until `osc_ready` rises.
- R8: `bor_evt` or `mclr_evt` in IDLE or SLEEP wakes the core (same paths as R4 and R5) and sets the flag of the mode it was in.
- R9: `por_evt` from any mode returns to RUN on the next edge and clears `stat_sleep`, `stat_idle`, `stat_wdto` and `frc_sel`.
- R10: `wdt_timeout` with `wdt_en`=1 in IDLE or SLEEP wakes the core and sets both the mode flag and `stat_wdto`; with `wdt_en`=0 it is ignored.
- R11: An interrupt wake sets the flag of the mode left and pulses `wake_irq` for one cycle.
- R12: Flags are sticky; `stat_clr` bit 0 clears `stat_sleep`, bit 1 `stat_idle`, bit 2 `stat_wdto`; a set in the same cycle as a clear wins.
- R13: `lprc_en` follows `fscm_en` in every mode except SLEEP, where it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psave_req | input | 1 | Power-save request strobe |
| psave_sleep | input | 1 | Mode select: 1 Sleep, 0 Idle |
| irq_req | input | NIRQ | Interrupt request lines |
| irq_en | input | NIRQ | Per-line interrupt enables |
| irq_prio | input | NIRQ*PW | Packed per-line priorities |
| cpu_ipl | input | PW | Current core priority level |
| por_evt | input | 1 | Power-on reset cause |
| bor_evt | input | 1 | Brown-out reset cause |
| mclr_evt | input | 1 | External reset pin cause |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_timeout | input | 1 | Watchdog time-out |
| fscm_en | input | 1 | Clock-fail monitoring enabled |
| osc_ready | input | 1 | Primary oscillator stable |
| osc_restore | input | 1 | Strobe returning to the primary oscillator |
| stab_load | input | CW | Start-up wait length in cycles |
| stat_clr | input | 3 | Flag clear strobes (wdto, idle, sleep) |
| mode_state | output | 2 | Mode: 0 RUN, 1 IDLE, 2 SLEEP, 3 WAKE_WAIT |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| posc_en | output | 1 | Primary oscillator enable |
| lprc_en | output | 1 | Low-power RC enable for fail detection |
| frc_sel | output | 1 | Backup internal oscillator selected |
| cf_trap | output | 1 | Clock-failure trap pulse |
| wake_irq | output | 1 | Interrupt wake pulse |
| stat_sleep | output | 1 | Woke from Sleep flag |
| stat_idle | output | 1 | Woke from Idle flag |
| stat_wdto | output | 1 | Watchdog wake flag |

## Verification
The interrupt wake test walks a table of request, enable, priority and level combinations from Idle: a qualifying line, a masked line, a priority equal to the level, a priority below it, the highest line, an enable on the wrong line, two requests of which only one qualifies and all lines enabled with none requesting. These separate a strict from a non-strict priority compare, an AND from an OR of request and enable, and the packing of the priority fields. Directed tests then exercise Sleep exit with a ready oscillator, a late oscillator with and without fail monitoring, the reset causes, the watchdog with and without its enable, and a flag clear that collides with a set.

// File: rtl/lpwr_wake_ctrl.sv
module lpwr_wake_ctrl #(
  parameter int NIRQ = 8,
  parameter int PW   = 3,
  parameter int CW   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psave_req,
  input  logic             psave_sleep,
  input  logic [NIRQ-1:0]  irq_req,
  input  logic [NIRQ-1:0]  irq_en,
  input  logic [NIRQ*PW-1:0] irq_prio,
  input  logic [PW-1:0]    cpu_ipl,
  input  logic             por_evt,
  input  logic             bor_evt,
  input  logic             mclr_evt,
  input  logic             wdt_en,
  input  logic             wdt_timeout,
  input  logic             fscm_en,
  input  logic             osc_ready,
  input  logic             osc_restore,
  input  logic [CW-1:0]    stab_load,
  input  logic [2:0]       stat_clr,
  output logic [1:0]       mode_state,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             posc_en,
  output logic             lprc_en,
  output logic             frc_sel,
  output logic             cf_trap,
  output logic             wake_irq,
  output logic             stat_sleep,
  output logic             stat_idle,
  output logic             stat_wdto
);

  localparam logic [1:0] S_RUN  = 2'd0;
  localparam logic [1:0] S_IDLE = 2'd1;
  localparam logic [1:0] S_SLP  = 2'd2;
  localparam logic [1:0] S_WAIT = 2'd3;

  logic [1:0]    state, nxt;
  logic [CW-1:0] cnt;
  logic          irq_hit;

  always_comb begin
    irq_hit = 1'b0;
    for (int i = 0; i < NIRQ; i++)
      if (irq_req[i] && irq_en[i] && (irq_prio[PW*i +: PW] > cpu_ipl))
        irq_hit = 1'b1;
  end

  wire lowp     = (state == S_IDLE) || (state == S_SLP);
  wire rst_wake = lowp && (bor_evt || mclr_evt);
  wire wdt_wake = lowp && wdt_en && wdt_timeout;
  wire irq_wake = lowp && irq_hit;
  wire any_wake = rst_wake || wdt_wake || irq_wake;
  wire cnt_zero = (cnt == '0);
  wire in_wait  = (state == S_WAIT);
  wire wait_ok  = in_wait && cnt_zero && osc_ready;
  wire wait_bad = in_wait && cnt_zero && !osc_ready && fscm_en;

  wire set_slp  = !por_evt && (state == S_SLP) && any_wake;
  wire set_idl  = !por_evt && (state == S_IDLE) && any_wake;
  wire set_wdt  = !por_evt && wdt_wake;

  always_comb begin
    nxt = state;
    if (por_evt) nxt = S_RUN;
    else begin
      case (state)
        S_RUN:   if (psave_req) nxt = psave_sleep ? S_SLP : S_IDLE;
        S_IDLE:  if (any_wake) nxt = S_RUN;
        S_SLP:   if (any_wake) nxt = S_WAIT;
        default: if (wait_ok || wait_bad) nxt = S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_RUN;
      cnt        <= '0;
      stat_sleep <= 1'b0;
      stat_idle  <= 1'b0;
      stat_wdto  <= 1'b0;
      frc_sel    <= 1'b0;
      cf_trap    <= 1'b0;
      wake_irq   <= 1'b0;
    end else begin
      state <= nxt;
      if (set_slp)                 cnt <= stab_load;
      else if (in_wait && !cnt_zero) cnt <= cnt - 1'b1;

      if (por_evt)          stat_sleep <= 1'b0;
      else if (set_slp)     stat_sleep <= 1'b1;
      else if (stat_clr[0]) stat_sleep <= 1'b0;

      if (por_evt)          stat_idle <= 1'b0;
      else if (set_idl)     stat_idle <= 1'b1;
      else if (stat_clr[1]) stat_idle <= 1'b0;

      if (por_evt)          stat_wdto <= 1'b0;
      else if (set_wdt)     stat_wdto <= 1'b1;
      else if (stat_clr[2]) stat_wdto <= 1'b0;

      if (por_evt)          frc_sel <= 1'b0;
      else if (wait_bad)    frc_sel <= 1'b1;
      else if (osc_restore) frc_sel <= 1'b0;

      cf_trap  <= !por_evt && wait_bad;
      wake_irq <= !por_evt && irq_wake;
    end
  end

  assign mode_state    = state;
  assign cpu_clk_en    = (state == S_RUN);
  assign periph_clk_en = (state == S_RUN) || (state == S_IDLE);
  assign posc_en       = (state != S_SLP);
  assign lprc_en       = fscm_en && (state != S_SLP);

endmodule

// File: rtl/lpwr_wake_chk.sv
module lpwr_wake_chk #(
  parameter int NIRQ = 8,
  parameter int PW   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             psave_req,
  input logic             psave_sleep,
  input logic [NIRQ-1:0]  irq_req,
  input logic [NIRQ-1:0]  irq_en,
  input logic [NIRQ*PW-1:0] irq_prio,
  input logic [PW-1:0]    cpu_ipl,
  input logic             por_evt,
  input logic             wdt_en,
  input logic             wdt_timeout,
  input logic             fscm_en,
  input logic             osc_ready,
  input logic [2:0]       stat_clr,
  input logic [1:0]       mode_state,
  input logic             cpu_clk_en,
  input logic             frc_sel,
  input logic             cf_trap,
  input logic             stat_sleep,
  input logic             stat_idle,
  input logic             stat_wdto
);
  logic hit;
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NIRQ; i++)
      if (irq_req[i] && irq_en[i] && (irq_prio[PW*i +: PW] > cpu_ipl)) hit = 1'b1;
  end

  // R1
  idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_state == 2'd0 && psave_req && !psave_sleep && !por_evt) |=> mode_state == 2'd1);
  // R4
  idle_irq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_state == 2'd1 && hit && !por_evt) |=> (mode_state == 2'd0 && cpu_clk_en));
  // R5
  sleep_no_direct_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_state == 2'd2 && !por_evt) |=> mode_state != 2'd0);
  // R6
  trap_frc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cf_trap |-> (frc_sel && $past(fscm_en)));
  // R7
  hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_state == 2'd3 && !osc_ready && !fscm_en && !por_evt) |=> mode_state == 2'd3);
  // R9
  por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_evt |=> (mode_state == 2'd0 && !stat_sleep && !stat_idle && !stat_wdto && !frc_sel));
  // R10
  wdt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_state == 2'd1 || mode_state == 2'd2) && wdt_en && wdt_timeout && !por_evt) |=> stat_wdto);
  // R12
  idle_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_idle && !stat_clr[1] && !por_evt) |=> stat_idle);
endmodule

bind lpwr_wake_ctrl lpwr_wake_chk #(.NIRQ(NIRQ), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .psave_req(psave_req), .psave_sleep(psave_sleep),
  .irq_req(irq_req), .irq_en(irq_en), .irq_prio(irq_prio), .cpu_ipl(cpu_ipl),
  .por_evt(por_evt), .wdt_en(wdt_en), .wdt_timeout(wdt_timeout),
  .fscm_en(fscm_en), .osc_ready(osc_ready), .stat_clr(stat_clr),
  .mode_state(mode_state), .cpu_clk_en(cpu_clk_en), .frc_sel(frc_sel),
  .cf_trap(cf_trap), .stat_sleep(stat_sleep), .stat_idle(stat_idle),
  .stat_wdto(stat_wdto)
);

// File: tb/tb_lpwr_wake_ctrl.sv
`timescale 1ns/1ps
module tb_lpwr_wake_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic psave_req = 0, psave_sleep = 0;
  logic [7:0] irq_req = 0, irq_en = 0;
  logic [23:0] irq_prio = 0;
  logic [2:0] cpu_ipl = 0;
  logic por_evt = 0, bor_evt = 0, mclr_evt = 0, wdt_en = 0, wdt_timeout = 0;
  logic fscm_en = 0, osc_ready = 1, osc_restore = 0;
  logic [7:0] stab_load = 0;
  logic [2:0] stat_clr = 0;
  logic [1:0] mode_state;
  logic cpu_clk_en, periph_clk_en, posc_en, lprc_en, frc_sel, cf_trap, wake_irq;
  logic stat_sleep, stat_idle, stat_wdto;
  int nchk = 0, nbad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lpwr_wake_ctrl dut (.*);

  typedef struct packed {
    logic [7:0] req; logic [7:0] en; logic [23:0] prio; logic [2:0] ipl; logic wake;
  } vec_t;
  localparam vec_t VT [8] = '{
    '{8'h01, 8'h01, 24'h000005, 3'd3, 1'b1},
    '{8'h01, 8'h00, 24'h000005, 3'd3, 1'b0},
    '{8'h01, 8'h01, 24'h000005, 3'd5, 1'b0},
    '{8'h01, 8'h01, 24'h000005, 3'd6, 1'b0},
    '{8'h80, 8'h80, 24'h200000, 3'd0, 1'b1},
    '{8'h10, 8'hEF, 24'hFFFFFF, 3'd0, 1'b0},
    '{8'h0C, 8'h0C, 24'h000E80, 3'd6, 1'b1},
    '{8'h00, 8'hFF, 24'hFFFFFF, 3'd0, 1'b0}
  };

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic enter(logic s);
    psave_req = 1; psave_sleep = s; tick(); psave_req = 0;
  endtask
  task automatic por();
    por_evt = 1; tick(); por_evt = 0;
  endtask
  task automatic irq_on();
    irq_req = 8'h01; irq_en = 8'h01; irq_prio = 24'h000007; cpu_ipl = 0;
  endtask
  task automatic irq_off(); irq_req = 0; endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    // R1 reset state
    chk("R1 reset mode", mode_state, 0);
    chk("R1 reset cpu clk", cpu_clk_en, 1);
    chk("R1 reset flags", {stat_sleep, stat_idle, stat_wdto, frc_sel}, 0);

    // R3 R4 R11 vector table from Idle
    foreach (VT[k]) begin
      por(); enter(0);
      irq_req = VT[k].req; irq_en = VT[k].en; irq_prio = VT[k].prio; cpu_ipl = VT[k].ipl;
      tick();
      chk("R3 R4 vector wake", mode_state, VT[k].wake ? 0 : 1);
      chk("R11 vector idle flag", stat_idle, VT[k].wake);
      chk("R11 vector wake_irq", wake_irq, VT[k].wake);
      irq_req = 0; irq_en = 0; irq_prio = 0; cpu_ipl = 0;
      if (VT[k].wake) begin tick(); chk("R11 wake_irq one cycle", wake_irq, 0); end
    end

    // R2 R13 Idle clocks
    por(); fscm_en = 1; enter(0);
    chk("R1 idle mode", mode_state, 1);
    chk("R2 idle clocks", {cpu_clk_en, periph_clk_en, posc_en}, 3'b011);
    chk("R13 idle lprc", lprc_en, 1);

    // R10 watchdog
    wdt_timeout = 1; wdt_en = 0; tick();
    chk("R10 wdt disabled ignored", mode_state, 1);
    chk("R10 wdt disabled flag", stat_wdto, 0);
    wdt_en = 1; tick(); wdt_timeout = 0; wdt_en = 0;
    chk("R10 wdt wake", mode_state, 0);
    chk("R10 wdt flags", {stat_idle, stat_wdto}, 2'b11);

    // R12 set wins over clear, then clears
    enter(0); irq_on(); stat_clr = 3'b010; tick(); irq_off(); stat_clr = 0;
    chk("R12 set wins", stat_idle, 1);
    stat_clr = 3'b010; tick(); stat_clr = 0;
    chk("R12 clear idle", stat_idle, 0);
    chk("R12 wdto sticky", stat_wdto, 1);
    stat_clr = 3'b100; tick(); stat_clr = 0;
    chk("R12 clear wdto", stat_wdto, 0);

    // R8 brown-out in Idle, R9 POR clears
    enter(0); bor_evt = 1; tick(); bor_evt = 0;
    chk("R8 bor idle wake", mode_state, 0);
    chk("R8 bor idle flag", stat_idle, 1);
    por();
    chk("R9 por flags", {stat_sleep, stat_idle, stat_wdto}, 0);

    // R5 Sleep exit, oscillator ready
    fscm_en = 0; stab_load = 5; osc_ready = 1; enter(1);
    chk("R1 sleep mode", mode_state, 2);
    chk("R2 sleep clocks", {cpu_clk_en, periph_clk_en, posc_en}, 0);
    chk("R13 sleep lprc", lprc_en, 0);
    irq_on(); tick(); irq_off();
    chk("R5 wake wait", mode_state, 3);
    chk("R2 wait clocks", {cpu_clk_en, periph_clk_en, posc_en}, 3'b001);
    repeat (5) tick();
    chk("R5 still waiting", mode_state, 3);
    tick();
    chk("R5 run after wait", mode_state, 0);
    chk("R5 sleep flag", stat_sleep, 1);
    chk("R5 no fallback", frc_sel, 0);

    // R7 hold until oscillator ready, R8 external reset from Sleep
    por(); osc_ready = 0; stab_load = 2; enter(1);
    mclr_evt = 1; tick(); mclr_evt = 0;
    chk("R8 mclr sleep wait", mode_state, 3);
    chk("R8 mclr sleep flag", stat_sleep, 1);
    repeat (20) tick();
    chk("R7 held", mode_state, 3);
    chk("R7 cpu off", cpu_clk_en, 0);
    osc_ready = 1; tick();
    chk("R7 released", mode_state, 0);

    // R6 fallback
    por(); osc_ready = 0; fscm_en = 1; stab_load = 3; enter(1);
    irq_on(); tick(); irq_off();
    repeat (3) tick();
    chk("R6 waiting", mode_state, 3);
    tick();
    chk("R6 run on fallback", mode_state, 0);
    chk("R6 frc selected", frc_sel, 1);
    chk("R6 trap", cf_trap, 1);
    tick();
    chk("R6 trap one cycle", cf_trap, 0);
    chk("R6 frc sticky", frc_sel, 1);
    osc_restore = 1; tick(); osc_restore = 0;
    chk("R6 restore", frc_sel, 0);

    // R9 POR from Sleep
    osc_ready = 1; enter(1); por();
    chk("R9 por from sleep", mode_state, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule